// File: doc/BRIEF.md
# Carry-Predicated Dual-Width Integer ALU

This unit performs the integer add, subtract and compare operations of a small processor whose general registers are 24 bits wide. Each operation runs either on 16-bit data or on full 24-bit addresses. Add, subtract and compare each have a variant that also takes in the carry flag, and those variants are always 16-bit. The second operand is either a register value or a 7-bit immediate.

Register-register operations can be made conditional on the current carry flag. When the condition is false the operation has no visible effect. A compare updates only the flags. The caller supplies the current destination value (a general register or the stack pointer) on `src_a`. For 24-bit add and subtract this may be the stack pointer, and the caller routes the result back to it.

The unit takes one operation per cycle when `in_valid` is high. It presents the result, a write strobe and the new flags one clock later.

Top module: `carry_alu`

## Requirements
- R1: An operation accepted with `in_valid` high at a rising edge appears on the outputs after that edge, with `out_valid` high for exactly one cycle per accepted operation. `wr_en` is low whenever `out_valid` is low.
- R2: Operation codes are 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-carry, 4 compare, 5 compare-with-carry. With `wide`=0, add and subtract work modulo 2^16. The C flag (`flags` bit 0) is the carry out for add and the borrow for subtract.
- R3: Add-with-carry computes a+b+C and subtract-with-carry computes a−b−C, where C is `flags_in` bit 0. These two operations and compare-with-carry are always 16-bit, whatever the value of `wide`.
- R4: With `wide`=1, add, subtract and compare work on all 24 bits, and every flag is taken at 24 bits.
- R5: A 16-bit operation that writes drives bits 23:16 of `result` to zero, whatever the upper bits of the operands are.
- R6: The 7-bit immediate is sign-extended for 16-bit compare and for compare-with-carry. For every other operation it is zero-extended.
- R7: Compare and compare-with-carry never raise `wr_en`, but they do update the flags.
- R8: `cond` selects predication: 0 and 3 always execute, 1 executes only if C=1, 2 executes only if C=0. A skipped operation, or a reserved code 6 or 7, gives `wr_en`=0 and `flags_out` equal to `flags_in`.
- R9: Immediate forms are never predicated. When `use_imm`=1, `cond` is ignored and the operation executes.
- R10: The flag word is {N,Z,V,C} in bits 3..0. N is the result MSB at the active width, Z is set when the result is zero at that width, and V is signed overflow at that width.
- R11: While `rst_n` is low, `out_valid`, `wr_en`, `result` and `flags_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 3 | Operation code (see R2) |
| wide | input | 1 | 1 selects the 24-bit address form |
| use_imm | input | 1 | 1 takes the second operand from `imm` |
| imm | input | 7 | Immediate operand |
| src_a | input | 24 | Destination's current value (register or stack pointer) |
| src_b | input | 24 | Second register operand |
| cond | input | 2 | Carry predication selector (see R8) |
| flags_in | input | 4 | Current flags {N,Z,V,C} |
| out_valid | output | 1 | Result of an accepted operation is present |
| result | output | 24 | Computed value |
| wr_en | output | 1 | Write `result` to the destination |
| flags_out | output | 4 | Updated flags {N,Z,V,C} |

## Verification
Directed operations are placed at the boundaries: 16-bit and 24-bit carry out, borrow out of zero, and signed overflow in both directions. These show whether the active width, the C polarity for subtract and the V rule are right. The same operands are sent with C set and clear to the carry-in variants, so that a missing or inverted carry input becomes visible. All four `cond` codes are combined with both values of C, and repeated with the immediate form, which separates correct predication from predication that is inverted or also applies to immediates. A series of random operations is then checked against a bench model of the flag and result rules.

// File: rtl/carry_alu_pkg.sv
// Shared types for the carry-predicated ALU.
// Assumes flags are packed {N,Z,V,C} with C in bit 0.
package carry_alu_pkg;
    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_SUB = 3'd2,
        OP_SBC = 3'd3,
        OP_CMP = 3'd4,
        OP_CMC = 3'd5
    } alu_op_e;

    typedef enum logic [1:0] {
        CND_ALWAYS = 2'd0,
        CND_IF_C   = 2'd1,
        CND_IF_NC  = 2'd2,
        CND_ALT    = 2'd3
    } alu_cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } alu_flags_t;
endpackage

// File: rtl/carry_alu_decode.sv
// Operation decoder: derives width, direction, carry use, immediate
// signedness and the predication decision from the opcode and flags.
// Assumes it is purely combinational and evaluated in the issue cycle.
module carry_alu_decode
    import carry_alu_pkg::*;
(
    input  logic [2:0] op,
    input  logic       wide,
    input  logic       use_imm,
    input  logic [1:0] cond,
    input  logic       c_flag,
    output logic       narrow,
    output logic       is_sub,
    output logic       use_cin,
    output logic       sign_imm,
    output logic       exec,
    output logic       writes
);
    logic op_ok;
    logic is_cmp;
    logic cond_ok;

    // Classify the opcode and decide whether it executes.
    always_comb begin
        op_ok    = (op <= OP_CMC);
        is_cmp   = (op == OP_CMP) || (op == OP_CMC);
        use_cin  = (op == OP_ADC) || (op == OP_SBC) || (op == OP_CMC);
        is_sub   = (op == OP_SUB) || (op == OP_SBC) || is_cmp;
        narrow   = !wide || use_cin;
        sign_imm = narrow && is_cmp;
        unique case (alu_cond_e'(cond))
            CND_IF_C:  cond_ok = c_flag;
            CND_IF_NC: cond_ok = !c_flag;
            default:   cond_ok = 1'b1;
        endcase
        exec   = op_ok && (use_imm || cond_ok);
        writes = exec && !is_cmp;
    end
endmodule

// File: rtl/carry_alu_operand.sv
// Second-operand selector: picks the register value or the immediate,
// extending the immediate by sign or by zero as the decoder requests.
// Assumes IMM_W is smaller than ADDR_W.
module carry_alu_operand #(
    parameter int ADDR_W = 24,
    parameter int IMM_W  = 7
) (
    input  logic [ADDR_W-1:0] src_b,
    input  logic [IMM_W-1:0]  imm,
    input  logic              use_imm,
    input  logic              sign_imm,
    output logic [ADDR_W-1:0] b_val
);
    localparam int EXT_W = ADDR_W - IMM_W;

    logic [EXT_W-1:0] ext_bits;

    // Form the extended immediate and choose the operand source.
    always_comb begin
        ext_bits = sign_imm ? {EXT_W{imm[IMM_W-1]}} : '0;
        b_val    = use_imm ? {ext_bits, imm} : src_b;
    end
endmodule

// File: rtl/carry_alu_core.sv
// Fixed-width adder/subtractor with N, Z, V, C flag generation.
// Subtraction is a + ~b + ~borrow; C reports the borrow for subtract.
// Assumes W >= 2.
module carry_alu_core
    import carry_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         is_sub,
    input  logic         cin,
    output logic [W-1:0] sum,
    output alu_flags_t   flg
);
    logic [W-1:0] b_eff;
    logic         c0;
    logic [W:0]   wide_sum;

    // Add or subtract and derive the four flags at width W.
    always_comb begin
        b_eff    = is_sub ? ~b : b;
        c0       = is_sub ? ~cin : cin;
        wide_sum = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c0};
        sum      = wide_sum[W-1:0];
        flg.c    = is_sub ? ~wide_sum[W] : wide_sum[W];
        flg.n    = sum[W-1];
        flg.z    = (sum == '0);
        flg.v    = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    end
endmodule

// File: rtl/carry_alu.sv
// Top of the dual-width ALU. Runs a 16-bit and a 24-bit datapath
// side by side, chooses one by the decoded width and registers the
// result, write strobe and flags. One operation per cycle, latency one.
// Assumes DATA_W < ADDR_W.
module carry_alu
    import carry_alu_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 24,
    parameter int IMM_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        op,
    input  logic              wide,
    input  logic              use_imm,
    input  logic [IMM_W-1:0]  imm,
    input  logic [ADDR_W-1:0] src_a,
    input  logic [ADDR_W-1:0] src_b,
    input  logic [1:0]        cond,
    input  logic [3:0]        flags_in,
    output logic              out_valid,
    output logic [ADDR_W-1:0] result,
    output logic              wr_en,
    output logic [3:0]        flags_out
);
    localparam int HI_W = ADDR_W - DATA_W;

    alu_flags_t        cur_flags;
    logic              narrow, is_sub, use_cin, sign_imm, exec, writes;
    logic              cin;
    logic [ADDR_W-1:0] b_val;
    logic [DATA_W-1:0] sum_lo;
    logic [ADDR_W-1:0] sum_hi;
    alu_flags_t        flg_lo, flg_hi;
    logic [ADDR_W-1:0] next_res;
    alu_flags_t        next_flg;

    assign cur_flags = alu_flags_t'(flags_in);
    assign cin       = use_cin && cur_flags.c;

    carry_alu_decode u_dec (
        .op       (op),
        .wide     (wide),
        .use_imm  (use_imm),
        .cond     (cond),
        .c_flag   (cur_flags.c),
        .narrow   (narrow),
        .is_sub   (is_sub),
        .use_cin  (use_cin),
        .sign_imm (sign_imm),
        .exec     (exec),
        .writes   (writes)
    );

    carry_alu_operand #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_opnd (
        .src_b    (src_b),
        .imm      (imm),
        .use_imm  (use_imm),
        .sign_imm (sign_imm),
        .b_val    (b_val)
    );

    carry_alu_core #(.W(DATA_W)) u_core_lo (
        .a      (src_a[DATA_W-1:0]),
        .b      (b_val[DATA_W-1:0]),
        .is_sub (is_sub),
        .cin    (cin),
        .sum    (sum_lo),
        .flg    (flg_lo)
    );

    carry_alu_core #(.W(ADDR_W)) u_core_hi (
        .a      (src_a),
        .b      (b_val),
        .is_sub (is_sub),
        .cin    (cin),
        .sum    (sum_hi),
        .flg    (flg_hi)
    );

    // Pick the active-width result and keep old flags when skipped.
    always_comb begin
        next_res = narrow ? {{HI_W{1'b0}}, sum_lo} : sum_hi;
        if (!exec)
            next_flg = cur_flags;
        else if (narrow)
            next_flg = flg_lo;
        else
            next_flg = flg_hi;
    end

    // Output register stage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            wr_en     <= 1'b0;
            result    <= '0;
            flags_out <= '0;
        end else if (in_valid) begin
            out_valid <= 1'b1;
            wr_en     <= writes;
            result    <= next_res;
            flags_out <= next_flg;
        end else begin
            out_valid <= 1'b0;
            wr_en     <= 1'b0;
        end
    end
endmodule

// File: rtl/carry_alu_chk.sv
// Assertion checker for carry_alu, attached by bind below.
module carry_alu_chk #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 24,
    parameter int IMM_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [2:0]        op,
    input logic              wide,
    input logic              use_imm,
    input logic [1:0]        cond,
    input logic [3:0]        flags_in,
    input logic              out_valid,
    input logic [ADDR_W-1:0] result,
    input logic              wr_en,
    input logic [3:0]        flags_out
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R1
    AST_WR_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !wr_en); // R1
    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ($past(op) == 3'd4 || $past(op) == 3'd5)) |-> !wr_en); // R7
    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (!$past(wide) || $past(op) == 3'd1 || $past(op) == 3'd3))
        |-> (result[ADDR_W-1:DATA_W] == '0)); // R5
    AST_SKIP_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !wr_en && $past(op) != 3'd4 && $past(op) != 3'd5)
        |-> (flags_out == $past(flags_in))); // R8
    AST_PRED_IF_C: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(use_imm) && $past(cond) == 2'd1 && !$past(flags_in[0]))
        |-> !wr_en); // R8
    AST_IMM_UNPREDICATED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(use_imm) && $past(op) <= 3'd3) |-> wr_en); // R9
    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (flags_out[2] == (result == '0))); // R10
endmodule

bind carry_alu carry_alu_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .wide      (wide),
    .use_imm   (use_imm),
    .cond      (cond),
    .flags_in  (flags_in),
    .out_valid (out_valid),
    .result    (result),
    .wr_en     (wr_en),
    .flags_out (flags_out)
);

// File: tb/carry_alu_test.sv
// Scoreboard bench: the driver pushes model-predicted items, the
// monitor pops and compares them as results come out.
module carry_alu_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op = '0;
    logic        wide = 1'b0;
    logic        use_imm = 1'b0;
    logic [6:0]  imm = '0;
    logic [23:0] src_a = '0;
    logic [23:0] src_b = '0;
    logic [1:0]  cond = '0;
    logic [3:0]  flags_in = '0;
    logic        out_valid;
    logic [23:0] result;
    logic        wr_en;
    logic [3:0]  flags_out;

    typedef struct packed {
        logic [23:0] res;
        logic        wr;
        logic [3:0]  fl;
    } exp_t;

    exp_t  q_exp[$];
    string q_tag[$];
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;

    always #4 clk = ~clk;

    carry_alu uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .wide(wide),
        .use_imm(use_imm), .imm(imm), .src_a(src_a), .src_b(src_b),
        .cond(cond), .flags_in(flags_in), .out_valid(out_valid),
        .result(result), .wr_en(wr_en), .flags_out(flags_out)
    );

    // Reference model built from the requirements.
    function automatic exp_t model(input logic [2:0] o, input logic wd, input logic ui,
                                   input logic [6:0] im, input logic [23:0] a,
                                   input logic [23:0] b, input logic [1:0] cd,
                                   input logic [3:0] fl);
        exp_t e;
        bit carry_op = (o == 3'd1) || (o == 3'd3) || (o == 3'd5);
        bit cmp_op   = (o == 3'd4) || (o == 3'd5);
        bit sub_op   = (o == 3'd2) || (o == 3'd3) || cmp_op;
        bit nar      = !wd || carry_op;
        int w        = nar ? 16 : 24;
        logic [31:0] mask = (32'h1 << w) - 1;
        logic [31:0] bv, aa, bb, s, r, ci;
        bit c, n, z, v, ex, cok;
        if (ui) begin
            if (nar && cmp_op) bv = {{25{im[6]}}, im};
            else               bv = {25'b0, im};
        end else bv = {8'b0, b};
        aa = {8'b0, a} & mask;
        bb = bv & mask;
        ci = carry_op ? {31'b0, fl[0]} : 32'd0;
        if (sub_op) begin
            s = aa - bb - ci;
            c = (aa < bb + ci);
        end else begin
            s = aa + bb + ci;
            c = s[w];
        end
        r = s & mask;
        n = r[w-1];
        z = (r == 0);
        if (sub_op) v = (aa[w-1] != bb[w-1]) && (r[w-1] != aa[w-1]);
        else        v = (aa[w-1] == bb[w-1]) && (r[w-1] != aa[w-1]);
        cok = (cd == 2'd0) || (cd == 2'd3) || (cd == 2'd1 && fl[0]) || (cd == 2'd2 && !fl[0]);
        ex = (o <= 3'd5) && (ui || cok);
        e.res = r[23:0];
        e.wr  = ex && !cmp_op;
        e.fl  = ex ? {n, z, v, c} : fl;
        return e;
    endfunction

    // Driver: present one operation and queue its expected outcome.
    task automatic send(input logic [2:0] o, input logic wd, input logic ui,
                        input logic [6:0] im, input logic [23:0] a, input logic [23:0] b,
                        input logic [1:0] cd, input logic [3:0] fl, input string tag);
        @(negedge clk);
        op = o; wide = wd; use_imm = ui; imm = im; src_a = a; src_b = b;
        cond = cd; flags_in = fl; in_valid = 1'b1;
        q_exp.push_back(model(o, wd, ui, im, a, b, cd, fl));
        q_tag.push_back(tag);
    endtask

    // Monitor: compare each produced result with the queue head.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            checks++;
            if (q_exp.size() == 0) begin
                errors++;
                $display("FAIL R1 unexpected output: actual=valid expected=idle");
            end else begin
                exp_t e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                if (wr_en !== e.wr || flags_out !== e.fl || (e.wr && result !== e.res)) begin
                    errors++;
                    $display("FAIL %s: actual res=%h wr=%b fl=%b expected res=%h wr=%b fl=%b",
                             t, result, wr_en, flags_out, e.res, e.wr, e.fl);
                end
            end
        end
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || wr_en !== 1'b0 || result !== '0 || flags_out !== '0) begin
            errors++;
            $display("FAIL R11 reset: actual v=%b wr=%b res=%h fl=%b expected all zero",
                     out_valid, wr_en, result, flags_out);
        end
        rst_n = 1'b1;
        // 16-bit arithmetic, overflow and upper-bit clearing
        send(3'd0, 0, 0, 0, 24'hAB7FFF, 24'h000001, 0, 4'b0000, "R5 R10 add16 signed overflow");
        send(3'd0, 0, 0, 0, 24'h00FFFF, 24'h000001, 0, 4'b0000, "R2 add16 carry out");
        send(3'd2, 0, 0, 0, 24'h000000, 24'h000001, 0, 4'b0000, "R2 sub16 borrow");
        send(3'd2, 0, 0, 0, 24'h008000, 24'h000001, 0, 4'b0000, "R10 sub16 overflow");
        // 24-bit forms
        send(3'd0, 1, 0, 0, 24'hFFFFFF, 24'h000001, 0, 4'b0000, "R4 add24 carry out");
        send(3'd0, 1, 0, 0, 24'h00FFFF, 24'h000001, 0, 4'b0000, "R4 add24 past 16 bits");
        send(3'd2, 1, 0, 0, 24'h010000, 24'h000001, 0, 4'b0000, "R4 sub24 borrow across 16");
        send(3'd4, 1, 0, 0, 24'h800000, 24'h000001, 0, 4'b0000, "R4 R7 cmp24 overflow");
        // carry-in variants
        send(3'd1, 0, 0, 0, 24'h000005, 24'h000006, 0, 4'b0001, "R3 adc C=1");
        send(3'd1, 0, 0, 0, 24'h000005, 24'h000006, 0, 4'b0000, "R3 adc C=0");
        send(3'd3, 0, 0, 0, 24'h00000A, 24'h000003, 0, 4'b0001, "R3 sbc C=1");
        send(3'd3, 0, 0, 0, 24'h00000A, 24'h000003, 0, 4'b0000, "R3 sbc C=0");
        send(3'd1, 1, 0, 0, 24'h12FFFF, 24'h000001, 0, 4'b0000, "R3 R5 adc forced 16-bit");
        send(3'd5, 0, 0, 0, 24'h000003, 24'h000003, 0, 4'b0001, "R3 R7 cmc borrow");
        // immediates
        send(3'd4, 0, 1, 7'h7F, 24'h00FFFF, 0, 0, 4'b0000, "R6 R7 cmp16 imm sign-extended");
        send(3'd4, 1, 1, 7'h7F, 24'h00007F, 0, 0, 4'b0000, "R6 cmp24 imm zero-extended");
        send(3'd0, 0, 1, 7'h7F, 24'h000001, 0, 0, 4'b0000, "R6 add16 imm zero-extended");
        send(3'd5, 0, 1, 7'h40, 24'h00FFC0, 0, 0, 4'b0000, "R6 cmc imm sign-extended");
        send(3'd0, 1, 1, 7'h10, 24'hFFFFF0, 0, 0, 4'b0000, "R4 R6 add24 imm to stack value");
        // predication
        send(3'd0, 0, 0, 0, 24'h000001, 24'h000001, 1, 4'b1110, "R8 if-C with C=0 skipped");
        send(3'd0, 0, 0, 0, 24'h000001, 24'h000001, 1, 4'b0001, "R8 if-C with C=1 runs");
        send(3'd2, 0, 0, 0, 24'h000009, 24'h000001, 2, 4'b0101, "R8 if-NC with C=1 skipped");
        send(3'd2, 0, 0, 0, 24'h000009, 24'h000001, 2, 4'b0100, "R8 if-NC with C=0 runs");
        send(3'd0, 1, 0, 0, 24'h000100, 24'h000001, 3, 4'b1111, "R8 cond 3 always runs");
        send(3'd6, 0, 0, 0, 24'h000001, 24'h000001, 0, 4'b0101, "R8 reserved code no effect");
        send(3'd0, 0, 1, 7'h02, 24'h000003, 0, 1, 4'b0000, "R9 imm ignores if-C");
        send(3'd2, 1, 1, 7'h01, 24'h000003, 0, 2, 4'b0001, "R9 imm ignores if-NC");
        // random series
        for (int i = 0; i < 40; i++) begin
            send(3'($urandom_range(5, 0)), 1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)),
                 7'($urandom), 24'($urandom), 24'($urandom), 2'($urandom_range(3, 0)),
                 4'($urandom), "R2 R10 random operation");
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        checks++;
        if (q_exp.size() != 0 || out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 drain: actual pending=%0d valid=%b expected 0 0",
                     q_exp.size(), out_valid);
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule